// File: doc/BRIEF.md
# Fault Status Register Bank

This block collects hardware fault pulses for one sub-block of a larger design and keeps them where software can see them. Fault sources are grouped into classes of `FAULT_W` bits. Each class owns three registers: a sticky status register that software clears by writing ones, a mask register that keeps chosen bits out of the fault summary, and a force register that lets software raise status bits without a real fault. A separate stall group has the same three registers, but its status is a live view of the stall inputs rather than a latched one.

A read-only summary register shows which classes hold unmasked active bits. The single output `fault_any_o` is a positive-level OR of that summary and goes to a chip-level fault monitor. One read/write injection register per class drives `inject_o`, which the fault sources use to create deliberate protocol or memory-parity errors. All access goes through an AXI4-Lite slave, and everything runs on one clock with an active-low synchronous reset.

Top module: `fault_bank`

## Requirements
- R1: After reset, every status, mask, force and injection register reads 0, `inject_o` is 0 and `fault_any_o` is 0.
- R2: Class c occupies the 16-byte slot at 0x010 + 0x10*c. Its status is at +0x0, its mask at +0x8 and its force at +0xC. A 1 on `fault_hw_i[c*FAULT_W+b]` for one cycle sets status bit b, and the bit stays set after the input returns to 0.
- R3: Writing 1 to a status bit clears it, and status bits written with 0 are unchanged. A byte lane whose `wstrb` bit is 0 is left untouched by every register write.
- R4: When a hardware fault and a software clear hit the same status bit in the same cycle, the bit stays set.
- R5: A force bit at 1 sets its status bit and keeps it set against clears. Mask and force registers read back what was written, and bits at or above `FAULT_W` read as 0.
- R6: A mask bit at 1 keeps that status bit out of the summary and out of `fault_any_o`, but the status bit still latches.
- R7: The summary register at 0x000 is read-only. Its bit c is 1 when class c has a set, unmasked status bit. Its bit `NUM_CLASSES` is 1 when the stall group has a set, unmasked status bit.
- R8: The stall slot sits at 0x010 + 0x10*`NUM_CLASSES` (0x050 by default), laid out like a class slot. Its status is `stall_hw_i` OR its force register. It is not sticky, and writes to it are ignored.
- R9: The injection register of class c is at 0x010 + 0x10*(`NUM_CLASSES`+1) + 4*c (0x060 + 4*c by default). It is read/write and drives `inject_o[c*FAULT_W +: FAULT_W]`.
- R10: A read from an unmapped address returns 0. A write to an unmapped address changes nothing. Every write response and read response is OKAY (0).
- R11: A write response stays valid until `bready` is 1. A read response stays valid, with stable data, until `rready` is 1.
- R12: `fault_any_o` is 1 exactly when some summary bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers, bus and fault output |
| rst_n | input | 1 | Active-low synchronous reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte enables |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response code |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response code |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| fault_hw_i | input | NUM_CLASSES*FAULT_W | Fault pulses, class c in bits c*FAULT_W upward |
| stall_hw_i | input | FAULT_W | Live stall indications |
| inject_o | output | NUM_CLASSES*FAULT_W | Fault-injection controls, one field per class |
| fault_any_o | output | 1 | Level OR of all unmasked active faults |

## Verification
The bench raises a fault in the same cycle that software clears it. A design that gives the clear priority would drop a fault that really happened. It keeps force bits set while software clears them, and a design that lets the clear win would show a forced bit as zero. It masks a bit and then raises it, expecting the status to latch while `fault_any_o` stays low. A design that gates the latch with the mask would lose the record, and one that ignores the mask would raise the line. It also writes into the stall status, the summary register, disabled byte lanes, the unused word inside a slot and unmapped space, and drops the stall input. A design that treats any of these as writable, or makes the stall status sticky, would return nonzero or stale data.

// File: rtl/fault_bank_pkg.sv
package fault_bank_pkg;

  // word position inside a 16-byte slot (address bits [3:2])
  typedef enum logic [1:0] {
    SUB_STATUS = 2'd0,
    SUB_GAP    = 2'd1,
    SUB_MASK   = 2'd2,
    SUB_FORCE  = 2'd3
  } sub_e;

  // expand byte enables into a bit mask
  function automatic logic [31:0] lane_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{strb[i]}};
    return m;
  endfunction

endpackage

// File: rtl/fault_bank_axil.sv
module fault_bank_axil #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [31:0]       wr_lanes_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i
);
  import fault_bank_pkg::*;

  logic bvalid_q, rvalid_q;
  logic [31:0] rdata_q;
  logic rd_hs;

  // address and data are taken together, only when no response is pending
  assign wr_en_o    = s_awvalid && s_wvalid && !bvalid_q;
  assign s_awready  = wr_en_o;
  assign s_wready   = wr_en_o;
  assign wr_addr_o  = s_awaddr;
  assign wr_data_o  = s_wdata;
  assign wr_lanes_o = lane_mask(s_wstrb);

  assign s_arready = !rvalid_q;
  assign rd_hs     = s_arvalid && !rvalid_q;
  assign rd_addr_o = s_araddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_o)       bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (rd_hs) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (s_rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = 2'b00;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_rresp  = 2'b00;
endmodule

// File: rtl/fault_bank_slot.sv
module fault_bank_slot #(
  parameter int FAULT_W = 8,
  parameter bit STICKY  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FAULT_W-1:0] hw_i,
  input  logic               wr_stat_i,
  input  logic               wr_mask_i,
  input  logic               wr_force_i,
  input  logic [FAULT_W-1:0] wdata_i,
  input  logic [FAULT_W-1:0] lanes_i,
  output logic [FAULT_W-1:0] stat_o,
  output logic [FAULT_W-1:0] mask_o,
  output logic [FAULT_W-1:0] force_o,
  output logic [FAULT_W-1:0] clr_o,
  output logic               active_o
);
  logic [FAULT_W-1:0] mask_q, force_q;

  // attempted clear, named for the checker
  assign clr_o = wr_stat_i ? (wdata_i & lanes_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= '0;
    end else begin
      if (wr_mask_i)  mask_q  <= (mask_q  & ~lanes_i) | (wdata_i & lanes_i);
      if (wr_force_i) force_q <= (force_q & ~lanes_i) | (wdata_i & lanes_i);
    end
  end

  generate
    if (STICKY) begin : g_sticky
      logic [FAULT_W-1:0] stat_q;
      // set sources are ORed in after the clear, so a set wins
      always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_o) | hw_i | force_q;
      end
      assign stat_o = stat_q;
    end else begin : g_live
      assign stat_o = hw_i | force_q;
    end
  endgenerate

  assign mask_o   = mask_q;
  assign force_o  = force_q;
  assign active_o = |(stat_o & ~mask_q);
endmodule

// File: rtl/fault_bank.sv
module fault_bank
  import fault_bank_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int FAULT_W     = 8,
  parameter int ADDR_W      = 12,
  parameter int CLASS_BASE  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              s_axil_awaddr,
  input  logic                           s_axil_awvalid,
  output logic                           s_axil_awready,
  input  logic [31:0]                    s_axil_wdata,
  input  logic [3:0]                     s_axil_wstrb,
  input  logic                           s_axil_wvalid,
  output logic                           s_axil_wready,
  output logic [1:0]                     s_axil_bresp,
  output logic                           s_axil_bvalid,
  input  logic                           s_axil_bready,
  input  logic [ADDR_W-1:0]              s_axil_araddr,
  input  logic                           s_axil_arvalid,
  output logic                           s_axil_arready,
  output logic [31:0]                    s_axil_rdata,
  output logic [1:0]                     s_axil_rresp,
  output logic                           s_axil_rvalid,
  input  logic                           s_axil_rready,
  input  logic [NUM_CLASSES*FAULT_W-1:0] fault_hw_i,
  input  logic [FAULT_W-1:0]             stall_hw_i,
  output logic [NUM_CLASSES*FAULT_W-1:0] inject_o,
  output logic                           fault_any_o
);
  localparam int STALL_BASE = CLASS_BASE + 16 * NUM_CLASSES;
  localparam int INJ_BASE   = STALL_BASE + 16;
  localparam int INJ_END    = INJ_BASE + 4 * NUM_CLASSES;
  localparam int CIDX_W     = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1;
  localparam int SUM_W      = NUM_CLASSES + 1;

  typedef struct packed {
    logic              sum;
    logic              cls;
    logic              stall;
    logic              inj;
    logic [CIDX_W-1:0] idx;
    sub_e              sub;
  } dec_t;

  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    logic [ADDR_W-1:0] rel_c, rel_i;
    rel_c   = a - ADDR_W'(CLASS_BASE);
    rel_i   = a - ADDR_W'(INJ_BASE);
    d.sub   = sub_e'(a[3:2]);
    d.sum   = (a[ADDR_W-1:2] == '0);
    d.cls   = (a >= ADDR_W'(CLASS_BASE)) && (a < ADDR_W'(STALL_BASE));
    d.stall = (a >= ADDR_W'(STALL_BASE)) && (a < ADDR_W'(INJ_BASE));
    d.inj   = (a >= ADDR_W'(INJ_BASE))   && (a < ADDR_W'(INJ_END));
    d.idx   = d.inj ? rel_i[CIDX_W+1:2] : rel_c[CIDX_W+3:4];
    return d;
  endfunction

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, wr_lanes, rd_data_c;
  logic [FAULT_W-1:0] wd, wl;
  dec_t wdec, rdec;

  fault_bank_axil #(.ADDR_W(ADDR_W)) u_axil (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_axil_awaddr), .s_awvalid(s_axil_awvalid), .s_awready(s_axil_awready),
    .s_wdata(s_axil_wdata), .s_wstrb(s_axil_wstrb), .s_wvalid(s_axil_wvalid),
    .s_wready(s_axil_wready), .s_bresp(s_axil_bresp), .s_bvalid(s_axil_bvalid),
    .s_bready(s_axil_bready), .s_araddr(s_axil_araddr), .s_arvalid(s_axil_arvalid),
    .s_arready(s_axil_arready), .s_rdata(s_axil_rdata), .s_rresp(s_axil_rresp),
    .s_rvalid(s_axil_rvalid), .s_rready(s_axil_rready),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_lanes_o(wr_lanes),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data_c)
  );

  assign wdec = decode(wr_addr);
  assign rdec = decode(rd_addr);
  assign wd   = wr_data[FAULT_W-1:0];
  assign wl   = wr_lanes[FAULT_W-1:0];

  logic [NUM_CLASSES-1:0][FAULT_W-1:0] hw_v, stat_v, mask_v, force_v, clr_v, inj_q;
  logic [NUM_CLASSES-1:0]              act_v;
  logic [FAULT_W-1:0] stall_stat, stall_mask, stall_force, stall_clr;
  logic               stall_act;
  logic [SUM_W-1:0]   summary;

  assign hw_v = fault_hw_i;

  generate
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
      logic hit;
      assign hit = wr_en && wdec.cls && (wdec.idx == CIDX_W'(c));
      fault_bank_slot #(.FAULT_W(FAULT_W), .STICKY(1'b1)) u_slot (
        .clk(clk), .rst_n(rst_n), .hw_i(hw_v[c]),
        .wr_stat_i(hit && wdec.sub == SUB_STATUS),
        .wr_mask_i(hit && wdec.sub == SUB_MASK),
        .wr_force_i(hit && wdec.sub == SUB_FORCE),
        .wdata_i(wd), .lanes_i(wl),
        .stat_o(stat_v[c]), .mask_o(mask_v[c]), .force_o(force_v[c]),
        .clr_o(clr_v[c]), .active_o(act_v[c])
      );
      always_ff @(posedge clk) begin
        if (!rst_n) inj_q[c] <= '0;
        else if (wr_en && wdec.inj && wdec.idx == CIDX_W'(c))
          inj_q[c] <= (inj_q[c] & ~wl) | (wd & wl);
      end
    end
  endgenerate

  fault_bank_slot #(.FAULT_W(FAULT_W), .STICKY(1'b0)) u_stall (
    .clk(clk), .rst_n(rst_n), .hw_i(stall_hw_i),
    .wr_stat_i(wr_en && wdec.stall && wdec.sub == SUB_STATUS),
    .wr_mask_i(wr_en && wdec.stall && wdec.sub == SUB_MASK),
    .wr_force_i(wr_en && wdec.stall && wdec.sub == SUB_FORCE),
    .wdata_i(wd), .lanes_i(wl),
    .stat_o(stall_stat), .mask_o(stall_mask), .force_o(stall_force),
    .clr_o(stall_clr), .active_o(stall_act)
  );

  assign summary     = {stall_act, act_v};
  assign fault_any_o = |summary;
  assign inject_o    = inj_q;

  always_comb begin
    rd_data_c = '0;
    if (rdec.sum) begin
      rd_data_c = 32'(summary);
    end else if (rdec.cls) begin
      case (rdec.sub)
        SUB_STATUS: rd_data_c = 32'(stat_v[rdec.idx]);
        SUB_MASK:   rd_data_c = 32'(mask_v[rdec.idx]);
        SUB_FORCE:  rd_data_c = 32'(force_v[rdec.idx]);
        default:    rd_data_c = '0;
      endcase
    end else if (rdec.stall) begin
      case (rdec.sub)
        SUB_STATUS: rd_data_c = 32'(stall_stat);
        SUB_MASK:   rd_data_c = 32'(stall_mask);
        SUB_FORCE:  rd_data_c = 32'(stall_force);
        default:    rd_data_c = '0;
      endcase
    end else if (rdec.inj) begin
      rd_data_c = 32'(inj_q[rdec.idx]);
    end
  end
endmodule

// File: rtl/fault_bank_chk.sv
module fault_bank_chk #(
  parameter int NUM_CLASSES = 4,
  parameter int FAULT_W     = 8
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [NUM_CLASSES-1:0][FAULT_W-1:0] hw_v,
  input logic [NUM_CLASSES-1:0][FAULT_W-1:0] stat_v,
  input logic [NUM_CLASSES-1:0][FAULT_W-1:0] mask_v,
  input logic [NUM_CLASSES-1:0][FAULT_W-1:0] force_v,
  input logic [NUM_CLASSES-1:0][FAULT_W-1:0] clr_v,
  input logic [FAULT_W-1:0]                  stall_hw_i,
  input logic [FAULT_W-1:0]                  stall_stat,
  input logic [FAULT_W-1:0]                  stall_mask,
  input logic [FAULT_W-1:0]                  stall_force,
  input logic [FAULT_W-1:0]                  stall_clr,
  input logic                                fault_any_o,
  input logic                                bvalid,
  input logic                                bready,
  input logic                                rvalid,
  input logic                                rready,
  input logic [31:0]                         rdata
);
  generate
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_chk
      // R2
      hw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_v[c] != '0) |=> ((stat_v[c] & $past(hw_v[c])) == $past(hw_v[c])));
      // R2
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[c] == '0) |=> ((stat_v[c] & $past(stat_v[c])) == $past(stat_v[c])));
      // R4
      set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_v[c] & hw_v[c]) != '0) |=>
          ((stat_v[c] & $past(clr_v[c] & hw_v[c])) == $past(clr_v[c] & hw_v[c])));
      // R5
      force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_v[c] != '0) |=> ((stat_v[c] & $past(force_v[c])) == $past(force_v[c])));
      // R12
      class_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_v[c] & ~mask_v[c]) != '0) |-> fault_any_o);
    end
  endgenerate

  // R8
  stall_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_clr != '0) ##1 ($stable(stall_hw_i) && $stable(stall_force)) |-> $stable(stall_stat));
  // R12
  stall_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_hw_i & ~stall_mask) != '0) |-> fault_any_o);
  // R11
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R11
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

bind fault_bank fault_bank_chk #(.NUM_CLASSES(NUM_CLASSES), .FAULT_W(FAULT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_v(hw_v), .stat_v(stat_v), .mask_v(mask_v),
  .force_v(force_v), .clr_v(clr_v), .stall_hw_i(stall_hw_i), .stall_stat(stall_stat),
  .stall_mask(stall_mask), .stall_force(stall_force), .stall_clr(stall_clr),
  .fault_any_o(fault_any_o), .bvalid(s_axil_bvalid), .bready(s_axil_bready),
  .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata)
);

// File: tb/fault_bank_bench.sv
module fault_bank_bench;
  localparam int NC = 4;
  localparam int FW = 8;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [NC*FW-1:0] fault_hw = '0;
  logic [FW-1:0]    stall_hw = '0;
  logic [NC*FW-1:0] inject;
  logic             fault_any;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  fault_bank #(.NUM_CLASSES(NC), .FAULT_W(FW), .ADDR_W(AW)) u_fault_bank (
    .clk(clk), .rst_n(rst_n),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
    .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
    .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
    .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
    .s_axil_rvalid(rvalid), .s_axil_rready(rready),
    .fault_hw_i(fault_hw), .stall_hw_i(stall_hw), .inject_o(inject), .fault_any_o(fault_any)
  );

  task automatic check(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    check(10, "write response code", 32'(bresp), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 1;
    @(posedge clk); #1;
    arvalid = 0; d = rdata;
    check(10, "read response code", 32'(rresp), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic read_check(input int r, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(r, $sformatf("read %03h", a), d, exp);
  endtask

  task automatic pulse_hw(input int bitpos);
    @(negedge clk); fault_hw[bitpos] = 1'b1;
    @(negedge clk); fault_hw[bitpos] = 1'b0;
  endtask

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h018, 32'h000000A5, 4'hF, 4'd5},   // R5 mask class 0
    '{1'b1, 12'h018, 32'h000000A5, 4'hF, 4'd5},
    '{1'b0, 12'h018, 32'hFFFFFF00, 4'hE, 4'd3},   // R3 lane 0 disabled
    '{1'b1, 12'h018, 32'h000000A5, 4'hF, 4'd3},
    '{1'b0, 12'h038, 32'h0000FFFF, 4'hF, 4'd5},   // R5 upper bits dropped
    '{1'b1, 12'h038, 32'h000000FF, 4'hF, 4'd5},
    '{1'b0, 12'h064, 32'h0000005A, 4'hF, 4'd9},   // R9 inject class 1
    '{1'b1, 12'h064, 32'h0000005A, 4'hF, 4'd9},
    '{1'b0, 12'h004, 32'hFFFFFFFF, 4'hF, 4'd10},  // R10 unmapped
    '{1'b1, 12'h004, 32'h00000000, 4'hF, 4'd10},
    '{1'b1, 12'h014, 32'h00000000, 4'hF, 4'd10},
    '{1'b1, 12'hFFC, 32'h00000000, 4'hF, 4'd10},
    '{1'b0, 12'h058, 32'h00000007, 4'hF, 4'd8},   // R8 stall mask
    '{1'b1, 12'h058, 32'h00000007, 4'hF, 4'd8},
    '{1'b0, 12'h000, 32'h000000FF, 4'hF, 4'd7},   // R7 summary read-only
    '{1'b1, 12'h000, 32'h00000000, 4'hF, 4'd7}
  };

  task automatic summary_line;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      summary_line();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(1, "fault_any after reset", 32'(fault_any), 0);
    check(1, "inject after reset", inject, 0);
    read_check(1, 12'h010, 0);
    read_check(1, 12'h04C, 0);

    foreach (VECS[i]) begin
      if (VECS[i].rd) begin
        bus_read(VECS[i].addr, d);
        check(int'(VECS[i].req), $sformatf("vector %0d", i), d, VECS[i].data);
      end else begin
        bus_write(VECS[i].addr, VECS[i].data, VECS[i].strb);
      end
    end
    check(9, "inject port class 1", inject, 32'h00005A00);
    bus_write(12'h018, 0, 4'hF);
    bus_write(12'h038, 0, 4'hF);
    bus_write(12'h058, 0, 4'hF);

    // R2 sticky latch, R12 output, R7 summary
    pulse_hw(3);
    repeat (2) @(negedge clk);
    check(12, "fault_any after class0 fault", 32'(fault_any), 1);
    read_check(2, 12'h010, 32'h08);
    read_check(7, 12'h000, 32'h01);
    // R3 write-one-to-clear, selective and lane gated
    bus_write(12'h010, 32'h08, 4'hF);
    read_check(3, 12'h010, 0);
    pulse_hw(0); pulse_hw(7);
    bus_write(12'h010, 32'h01, 4'hF);
    read_check(3, 12'h010, 32'h80);
    bus_write(12'h010, 32'h80, 4'h0);
    read_check(3, 12'h010, 32'h80);
    bus_write(12'h010, 32'h80, 4'h1);
    read_check(3, 12'h010, 0);
    check(12, "fault_any after clears", 32'(fault_any), 0);

    // R4 hardware set in the clear cycle wins
    @(negedge clk); fault_hw[FW] = 1'b1;
    @(negedge clk);
    awaddr = 12'h020; wdata = 32'h01; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0; fault_hw[FW] = 1'b0;
    @(posedge clk); #1;
    read_check(4, 12'h020, 32'h01);
    bus_write(12'h020, 32'h01, 4'hF);
    read_check(4, 12'h020, 0);

    // R5 force keeps status set
    bus_write(12'h03C, 32'h04, 4'hF);
    read_check(5, 12'h030, 32'h04);
    bus_write(12'h030, 32'h04, 4'hF);
    read_check(5, 12'h030, 32'h04);
    read_check(5, 12'h03C, 32'h04);
    bus_write(12'h03C, 0, 4'hF);
    bus_write(12'h030, 32'h04, 4'hF);
    read_check(5, 12'h030, 0);

    // R6 mask hides from summary but status latches
    bus_write(12'h048, 32'h10, 4'hF);
    pulse_hw(3*FW + 4);
    repeat (2) @(negedge clk);
    check(6, "fault_any with masked fault", 32'(fault_any), 0);
    read_check(6, 12'h040, 32'h10);
    read_check(6, 12'h000, 0);
    bus_write(12'h048, 0, 4'hF);
    check(12, "fault_any after unmask", 32'(fault_any), 1);
    read_check(7, 12'h000, 32'h08);
    bus_write(12'h040, 32'h10, 4'hF);
    check(12, "fault_any after class3 clear", 32'(fault_any), 0);

    // R8 stall group is live and read-only
    @(negedge clk); stall_hw = 8'h02;
    @(negedge clk);
    check(12, "fault_any with stall", 32'(fault_any), 1);
    read_check(8, 12'h050, 32'h02);
    read_check(7, 12'h000, 32'h10);
    @(negedge clk); stall_hw = 8'h00;
    read_check(8, 12'h050, 0);
    check(8, "fault_any after stall drops", 32'(fault_any), 0);
    bus_write(12'h05C, 32'h01, 4'hF);
    read_check(8, 12'h050, 32'h01);
    bus_write(12'h050, 32'hFF, 4'hF);
    read_check(8, 12'h050, 32'h01);
    bus_write(12'h05C, 0, 4'hF);
    bus_write(12'h058, 32'h02, 4'hF);
    @(negedge clk); stall_hw = 8'h02;
    @(negedge clk);
    check(6, "fault_any with masked stall", 32'(fault_any), 0);
    @(negedge clk); stall_hw = 8'h00;
    bus_write(12'h058, 0, 4'hF);

    // R10 write into slot gap leaves neighbours alone
    bus_write(12'h014, 32'hFF, 4'hF);
    read_check(10, 12'h018, 0);
    read_check(10, 12'h010, 0);

    // R11 responses held while not accepted
    @(negedge clk);
    awaddr = 12'h068; wdata = 32'h33; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(11, "bvalid held", 32'(bvalid), 1);
    end
    bready = 1;
    @(posedge clk); #1;
    check(11, "bvalid released", 32'(bvalid), 0);
    @(negedge clk);
    araddr = 12'h068; arvalid = 1; rready = 0;
    @(posedge clk); #1;
    arvalid = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(11, "rvalid held", 32'(rvalid), 1);
      check(9, "held read data", rdata, 32'h33);
    end
    rready = 1;
    @(posedge clk); #1;
    check(11, "rvalid released", 32'(rvalid), 0);

    // R1 reset clears written state
    bus_write(12'h028, 32'h0F, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(1, "inject after second reset", inject, 0);
    read_check(1, 12'h028, 0);

    done = 1;
    summary_line();
    $finish;
  end
endmodule